// File: doc/BRIEF.md
# Sign-Magnitude Integer Adder

This block adds or subtracts two signed integers held in sign-magnitude form. It is W bits wide, 8 by default. The top bit of each word is the sign and the lower bits are an unsigned magnitude.

The datapath does not use a single carry adder over the full word. It works in these steps:

- It inverts the sign of the second operand when a subtraction is requested.
- It decides whether the effective signs match.
- If they match, it adds the magnitudes.
- If they differ, it compares the magnitudes, swaps them so the larger comes first, and subtracts.
- It picks the result sign and removes any negative-zero result.

A parameter decides whether the result leaves through a register stage or straight from the combinational logic.

A carry out of the magnitude field on a same-sign addition raises the overflow flag. The result word then carries the wrapped magnitude.

Typical users are sample-processing paths that keep data in sign-magnitude form end to end, so they need no conversion to two's complement.

Top module: `smag_adder`

## Requirements
- R1: Bit W-1 of every operand and of the result is the sign (0 positive, 1 negative), and bits W-2..0 are an unsigned magnitude. Values range from -(2^(W-1)-1) to +(2^(W-1)-1).
- R2: When the effective signs are equal, the result magnitude is the sum of the operand magnitudes and the result sign is that common sign.
- R3: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller, and the result takes the sign of the operand with the larger magnitude.
- R4: The overflow flag is 1 exactly when a same-sign magnitude addition carries out of the W-1 magnitude bits. It is always 0 when the effective signs differ.
- R5: On overflow, the result magnitude is the low W-1 bits of the true magnitude sum, and the result sign is the common sign (subject to R7).
- R6: A negative-zero operand (sign 1, magnitude 0) behaves exactly like positive zero.
- R7: Every result with magnitude 0 has sign 0, including equal magnitudes of opposite sign and a wrapped overflow to 0.
- R8: When the subtract control is 1, the sign of the second operand is inverted before the sign cases are decided, so the block computes a - b.
- R9: With REG_OUT=1 (default), sum and overflow appear one clock after the operands and are 0 while reset is asserted. With REG_OUT=0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_i | input | W | First operand, sign-magnitude |
| b_i | input | W | Second operand, sign-magnitude |
| sub_i | input | 1 | 1 selects a - b, 0 selects a + b |
| sum_o | output | W | Result, sign-magnitude, never negative zero |
| ovf_o | output | 1 | Magnitude overflow of a same-sign addition |

## Verification
Overflow and zero normalisation can hit the same result. This happens when two same-sign magnitudes sum to exactly 2^(W-1), for example -64 plus -64 at W=8. The carry must then be flagged while the wrapped magnitude of zero has its negative sign cleared. The bench provokes this case by sweeping every operand pair for both the add and the subtract control. Each pair is judged against an integer model that sums the signed values, reduces the magnitude modulo 2^(W-1) and forces the sign positive on zero, so the flag and the sign are checked on the same item.

// File: rtl/smag_pkg.sv
package smag_pkg;
  // Magnitude operation selected from the effective sign combination
  typedef enum logic {
    MAG_ADD = 1'b0,
    MAG_SUB = 1'b1
  } mag_op_e;
endpackage

// File: rtl/smag_order.sv
// Compares two magnitudes and routes the larger one to the hi lane.
module smag_order #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] mag_a,
  input  logic [MW-1:0] mag_b,
  input  logic          sign_a,
  input  logic          sign_b,
  output logic [MW-1:0] mag_hi,
  output logic [MW-1:0] mag_lo,
  output logic          sign_hi
);
  logic a_not_less;

  always_comb begin
    a_not_less = (mag_a >= mag_b);
    if (a_not_less) begin
      mag_hi  = mag_a;
      mag_lo  = mag_b;
      sign_hi = sign_a;
    end else begin
      mag_hi  = mag_b;
      mag_lo  = mag_a;
      sign_hi = sign_b;
    end
  end
endmodule

// File: rtl/smag_magunit.sv
// Unsigned magnitude adder/subtractor; subtraction assumes hi >= lo.
module smag_magunit
  import smag_pkg::*;
#(
  parameter int MW = 7
) (
  input  logic [MW-1:0] mag_hi,
  input  logic [MW-1:0] mag_lo,
  input  mag_op_e       op,
  output logic [MW-1:0] mag_res,
  output logic          carry
);
  logic [MW:0] wide;

  always_comb begin
    if (op == MAG_ADD) begin
      wide = {1'b0, mag_hi} + {1'b0, mag_lo};
    end else begin
      wide = {1'b0, mag_hi} - {1'b0, mag_lo};
    end
    mag_res = wide[MW-1:0];
    carry   = (op == MAG_ADD) & wide[MW];
  end
endmodule

// File: rtl/smag_pack.sv
// Joins sign and magnitude into a word, clearing the sign of a zero result.
module smag_pack #(
  parameter int W = 8
) (
  input  logic         sign_in,
  input  logic [W-2:0] mag_in,
  output logic [W-1:0] word_out
);
  logic mag_zero;

  always_comb begin
    mag_zero = (mag_in == '0);
    word_out = {sign_in & ~mag_zero, mag_in};
  end
endmodule

// File: rtl/smag_adder.sv
module smag_adder
  import smag_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam int MW = W - 1;

  // Operand decode; the subtract control flips the second sign
  logic          sgn_a;
  logic          sgn_b_eff;
  logic [MW-1:0] mag_a;
  logic [MW-1:0] mag_b;
  logic          signs_match;
  mag_op_e       op_sel;

  always_comb begin
    sgn_a       = a_i[W-1];
    sgn_b_eff   = b_i[W-1] ^ sub_i;
    mag_a       = a_i[MW-1:0];
    mag_b       = b_i[MW-1:0];
    signs_match = (sgn_a == sgn_b_eff);
    op_sel      = signs_match ? MAG_ADD : MAG_SUB;
  end

  logic [MW-1:0] mag_hi;
  logic [MW-1:0] mag_lo;
  logic          sign_hi;

  smag_order #(.MW(MW)) u_order (
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .sign_a (sgn_a),
    .sign_b (sgn_b_eff),
    .mag_hi (mag_hi),
    .mag_lo (mag_lo),
    .sign_hi(sign_hi)
  );

  logic [MW-1:0] mag_res;
  logic          mag_carry;

  smag_magunit #(.MW(MW)) u_magunit (
    .mag_hi (mag_hi),
    .mag_lo (mag_lo),
    .op     (op_sel),
    .mag_res(mag_res),
    .carry  (mag_carry)
  );

  logic res_sign;
  always_comb begin
    res_sign = signs_match ? sgn_a : sign_hi;
  end

  logic [W-1:0] sum_c;
  logic         ovf_c;

  smag_pack #(.W(W)) u_pack (
    .sign_in (res_sign),
    .mag_in  (mag_res),
    .word_out(sum_c)
  );

  assign ovf_c = mag_carry;

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] sum_q, sum_d;
      logic         ovf_q, ovf_d;

      always_comb begin
        sum_d = sum_c;
        ovf_d = ovf_c;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_q <= '0;
          ovf_q <= 1'b0;
        end else begin
          sum_q <= sum_d;
          ovf_q <= ovf_d;
        end
      end

      assign sum_o = sum_q;
      assign ovf_o = ovf_q;
    end else begin : g_comb
      assign sum_o = sum_c;
      assign ovf_o = ovf_c;
    end
  endgenerate
endmodule

// File: rtl/smag_adder_chk.sv
module smag_adder_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] sum_c,
  input logic         ovf_c,
  input logic [W-1:0] sum_o,
  input logic         ovf_o
);
  logic          eff_b_sign;
  logic          diff_signs;
  logic [W-2:0]  big_mag;
  assign eff_b_sign = b_i[W-1] ^ sub_i;
  assign diff_signs = a_i[W-1] ^ eff_b_sign;
  assign big_mag    = (a_i[W-2:0] >= b_i[W-2:0]) ? a_i[W-2:0] : b_i[W-2:0];

  // R7: a zero magnitude never leaves with a negative sign
  p_zero_positive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_c[W-2:0] == '0) |-> !sum_c[W-1]);

  // R4: mixed effective signs never overflow
  p_mixed_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    diff_signs |-> !ovf_c);

  // R2: same signs with nonzero result keep the common sign
  p_same_sign_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!diff_signs && (sum_c[W-2:0] != '0)) |-> (sum_c[W-1] == a_i[W-1]));

  // R5: a wrapped magnitude is below the first operand's magnitude
  p_wrap_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_c |-> (sum_c[W-2:0] < a_i[W-2:0]));

  // R3: a difference never exceeds the larger magnitude
  p_diff_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    diff_signs |-> (sum_c[W-2:0] <= big_mag));

  generate
    if (REG_OUT) begin : g_lat
      // R9: registered outputs carry the previous cycle's result
      p_reg_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sum_o == $past(sum_c)) && (ovf_o == $past(ovf_c))));
    end else begin : g_nolat
      always_comb begin
        if (rst_n) begin
          a_comb_follow_r9: assert ((sum_o == sum_c) && (ovf_o == ovf_c));
        end
      end
    end
  endgenerate
endmodule

bind smag_adder smag_adder_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .a_i  (a_i),
  .b_i  (b_i),
  .sub_i(sub_i),
  .sum_c(sum_c),
  .ovf_c(ovf_c),
  .sum_o(sum_o),
  .ovf_o(ovf_o)
);

// File: tb/test_smag_adder.sv
module test_smag_adder;
  localparam int W   = 8;
  localparam int LIM = 1 << (W - 1);

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i, b_i;
  logic         sub_i;
  logic [W-1:0] sum_o;
  logic         ovf_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [W-1:0] sum;
    logic         ovf;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    string        tag;
  } item_t;

  item_t q[$];

  smag_adder #(.W(W), .REG_OUT(1'b1)) i_smag_adder (
    .clk  (clk),
    .rst_n(rst_n),
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(sub_i),
    .sum_o(sum_o),
    .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Integer reference: signed sum, magnitude modulo 2^(W-1), zero forced positive
  function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b, logic sub);
    item_t it;
    int va, vb, r, ar, m;
    va = int'(a[W-2:0]);
    if (a[W-1]) va = -va;
    vb = int'(b[W-2:0]);
    if (b[W-1] ^ sub) vb = -vb;
    r  = va + vb;
    ar = (r < 0) ? -r : r;
    m  = ar % LIM;
    it.ovf = (ar >= LIM);
    it.sum = {((r < 0) && (m != 0)), m[W-2:0]};
    it.a = a; it.b = b; it.sub = sub;
    if (it.ovf)                                           it.tag = "R4,R5";
    else if (m == 0 && ((a[W-2:0] == 0) || (b[W-2:0] == 0))
             && (a[W-1] || b[W-1]))                       it.tag = "R6";
    else if (m == 0)                                      it.tag = "R7";
    else if (sub)                                         it.tag = "R8";
    else if (a[W-1] == b[W-1])                            it.tag = "R2";
    else                                                  it.tag = "R3";
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    @(negedge clk);
    a_i   = a;
    b_i   = b;
    sub_i = sub;
    q.push_back(model(a, b, sub));
  endtask

  // Monitor: one result per clock, one register after the operands (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_checks++;
        if (sum_o !== e.sum || ovf_o !== e.ovf) begin
          n_fail++;
          $display("FAIL %s,R1,R9: a=%h b=%h sub=%0d actual sum=%h ovf=%0d expected sum=%h ovf=%0d",
                   e.tag, e.a, e.b, e.sub, sum_o, ovf_o, e.sum, e.ovf);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a_i   = 8'h05;
    b_i   = 8'h07;
    sub_i = 1'b0;
    #25;
    // R9: outputs held at zero under reset even with live operands
    n_checks++;
    if (sum_o !== '0 || ovf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: actual sum=%h ovf=%0d expected sum=00 ovf=0", sum_o, ovf_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // Exhaustive sweep over both controls covers R1..R8
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < (1 << W); i++) begin
        for (int j = 0; j < (1 << W); j++) begin
          drive(i[W-1:0], j[W-1:0], s[0]);
        end
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule